// File: doc/BRIEF.md
# Staged Two-Segment Match Array

This block is a searchable table of fixed-width words. Software-side logic writes words into numbered entries through a simple write port. A search then runs in two phases, driven by an active-low precharge control. While that control is low, every per-entry match line and the two internal segment nodes of every entry return to their idle high level. The first clock edge that sees the control high again evaluates the search key against every valid entry at once.

Each word is split into a short leading segment (the top bits) and a longer trailing segment (the remaining low bits). An entry's trailing segment takes part in a search only after its leading segment has matched. That staging lets the block count how many trailing comparisons were actually enabled, which gives a figure for search activity. Match lines are active low: a line drops only for a full-word hit. The block also reports a hit flag and the lowest matching entry index.

Top module: `seg_cam`

## Requirements
- R1: After reset, every entry is invalid, all match lines are high, the hit flag is 0, the hit index is 0 and the activity counter is 0.
- R2: A clock edge with `wrEn` high stores `wrData` into entry `wrIdx` and marks that entry valid.
- R3: A clock edge with `preN` low returns every match line high and clears the hit flag.
- R4: The first clock edge with `preN` high after a low edge evaluates the search. The results stay unchanged on every following edge while `preN` stays high.
- R5: In an evaluation, an entry's match line goes low exactly when the entry is valid, its bits [15:12] equal `searchKey[15:12]`, and its bits [11:0] equal `searchKey[11:0]`.
- R6: An entry whose leading segment [15:12] differs from the key keeps its match line high, whatever its trailing segment holds. An entry whose leading segment matches but whose trailing segment differs also keeps its match line high.
- R7: `hit` is 1 exactly when some match line is low. `hitIdx` then gives the lowest-numbered low line; with no hit it is 0.
- R8: A write on the same edge as an evaluation does not affect that evaluation. The new word first takes part in the next search.
- R9: On each evaluation edge, `trailEvalCount` grows by the number of valid entries whose leading segment matched. On all other edges it is unchanged.
- R10: An entry never written since reset never reports a match and adds nothing to the counter, even for a key of 0x0000.
- R11: Changing `searchKey` after an evaluation, while `preN` stays high, has no effect on the match lines, the hit flag, the hit index or the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write enable for the addressed entry |
| wrIdx | input | IDX_W | Entry written |
| wrData | input | WORD_W | Word to store |
| preN | input | 1 | Precharge control; low precharges, a rise starts evaluation |
| searchKey | input | WORD_W | Key compared during evaluation |
| matchN | output | NUM_ENTRIES | Per-entry match lines, active low |
| hit | output | 1 | Some entry matched |
| hitIdx | output | IDX_W | Lowest matching entry |
| trailEvalCount | output | CNT_W | Number of enabled trailing-segment comparisons |

## Verification
Two cases are hard to reach from the ports. The first is a write landing on the very edge that evaluates. The bench raises `preN` and `wrEn` on the same falling edge, so both act on one rising edge, and it then checks that the overwritten entry still reports its old word. The second is an entry whose trailing segment matches the key but whose leading segment does not. Such an entry must neither hit nor count, so the bench uses keys built to match only the trailing bits of stored words and follows the exact counter delta on every search.

// File: rtl/seg_cam_pkg.sv
package seg_cam_pkg;
  // Strobes from the phase control to the datapath
  typedef struct packed {
    logic precharge;  // restore all nodes high this edge
    logic evaluate;   // compare key this edge
  } camStrobes_t;
endpackage

// File: rtl/seg_cam_ctrl.sv
module seg_cam_ctrl
  import seg_cam_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        preN,
  output camStrobes_t strobes
);
  // Previous sampled level of the precharge control; idle-high after reset
  logic preQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) preQ <= 1'b1;
    else        preQ <= preN;
  end

  always_comb begin
    strobes.precharge = !preN;
    strobes.evaluate  = preN && !preQ;
  end

  // R4: evaluation is a single edge per precharge release
  assert_single_eval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.evaluate |=> !strobes.evaluate);

  // R4: evaluation only follows a precharge edge
  assert_eval_after_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobes.evaluate) |-> $past(strobes.precharge));
endmodule

// File: rtl/seg_cam_prio.sv
module seg_cam_prio #(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0] matchLineN,
  output logic                   hit,
  output logic [IDX_W-1:0]       hitIdx
);
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    // scan downward so the lowest active entry wins
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!matchLineN[i]) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  // R7: reported index always points at a low match line
  always_comb begin
    if (hit) assert_idx_active_R7: assert (!matchLineN[hitIdx]);
  end
endmodule

// File: rtl/seg_cam_datapath.sv
module seg_cam_datapath
  import seg_cam_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int WORD_W      = 16,
  parameter int LEAD_W      = 4,
  parameter int CNT_W       = 16,
  localparam int IDX_W   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int TRAIL_W = WORD_W - LEAD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  camStrobes_t            strobes,
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [WORD_W-1:0]      wrData,
  input  logic [WORD_W-1:0]      searchKey,
  output logic [NUM_ENTRIES-1:0] matchLineN,
  output logic [CNT_W-1:0]       evalCount
);
  logic [WORD_W-1:0]      storeQ [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validQ;
  logic [NUM_ENTRIES-1:0] leadHit, trailEq;
  logic [NUM_ENTRIES-1:0] leadNodeD, trailNodeD, matchD;
  logic [NUM_ENTRIES-1:0] leadNodeQ, trailNodeQ, matchQ;

  // Word storage (no reset needed: validity gates use)
  always_ff @(posedge clk) begin
    if (wrEn) storeQ[wrIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    validQ <= '0;
    else if (wrEn) validQ[wrIdx] <= 1'b1;
  end

  // Per-entry staged compare
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    assign leadHit[g] = validQ[g] &&
      (storeQ[g][WORD_W-1 -: LEAD_W] == searchKey[WORD_W-1 -: LEAD_W]);
    assign trailEq[g] = (storeQ[g][TRAIL_W-1:0] == searchKey[TRAIL_W-1:0]);
    // leading node falls on a full leading match
    assign leadNodeD[g]  = !leadHit[g];
    // trailing node falls only when enabled and mismatching
    assign trailNodeD[g] = !(leadHit[g] && !trailEq[g]);
    // line discharges when leading node low and trailing node still high
    assign matchD[g]     = !(!leadNodeD[g] && trailNodeD[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leadNodeQ  <= '1;
      trailNodeQ <= '1;
      matchQ     <= '1;
    end else if (strobes.precharge) begin
      leadNodeQ  <= '1;
      trailNodeQ <= '1;
      matchQ     <= '1;
    end else if (strobes.evaluate) begin
      leadNodeQ  <= leadNodeD;
      trailNodeQ <= trailNodeD;
      matchQ     <= matchD;
    end
  end

  function automatic logic [CNT_W-1:0] popCount(input logic [NUM_ENTRIES-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) s = s + CNT_W'(v[i]);
    return s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                evalCount <= '0;
    else if (strobes.evaluate) evalCount <= evalCount + popCount(leadHit);
  end

  assign matchLineN = matchQ;

  // R3: precharge edge leaves every node high
  assert_precharge_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.precharge |=> (&matchQ && &leadNodeQ && &trailNodeQ));

  // R6: a low trailing node never coexists with a discharged line
  assert_trail_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~trailNodeQ) & (~matchQ)) == '0);

  // R6: trailing node only falls where the leading node fell
  assert_trail_needs_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~trailNodeQ) & leadNodeQ) == '0);

  // R10: invalid entries never hold a discharged line
  assert_invalid_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((~validQ) & (~matchQ)) == '0);

  // R9: counter moves only on evaluation edges
  assert_count_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.evaluate |=> $stable(evalCount));

  // R4: results hold between evaluation and next precharge
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.precharge && !strobes.evaluate) |=> $stable(matchQ));
endmodule

// File: rtl/seg_cam.sv
module seg_cam
  import seg_cam_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int WORD_W      = 16,
  parameter int LEAD_W      = 4,
  parameter int CNT_W       = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [WORD_W-1:0]      wrData,
  input  logic                   preN,
  input  logic [WORD_W-1:0]      searchKey,
  output logic [NUM_ENTRIES-1:0] matchN,
  output logic                   hit,
  output logic [IDX_W-1:0]       hitIdx,
  output logic [CNT_W-1:0]       trailEvalCount
);
  camStrobes_t strobes;

  seg_cam_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .preN    (preN),
    .strobes (strobes)
  );

  seg_cam_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .WORD_W      (WORD_W),
    .LEAD_W      (LEAD_W),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .searchKey  (searchKey),
    .matchLineN (matchN),
    .evalCount  (trailEvalCount)
  );

  seg_cam_prio #(.NUM_ENTRIES(NUM_ENTRIES)) u_prio (
    .matchLineN (matchN),
    .hit        (hit),
    .hitIdx     (hitIdx)
  );
endmodule

// File: tb/seg_cam_tb.sv
module seg_cam_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [15:0] wrData = '0;
  logic        preN = 1'b1;
  logic [15:0] searchKey = '0;
  logic [7:0]  matchN;
  logic        hit;
  logic [2:0]  hitIdx;
  logic [15:0] trailEvalCount;

  int errors = 0;
  int checks = 0;
  logic [15:0] expCount = '0;

  always #2 clk = ~clk;

  seg_cam u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .preN(preN), .searchKey(searchKey), .matchN(matchN), .hit(hit),
    .hitIdx(hitIdx), .trailEvalCount(trailEvalCount)
  );

  // {key, expected matchN, expected hit, expected index, counter delta}
  localparam logic [31:0] VECS [8] = '{
    {16'h1234, 8'hF6, 1'b1, 3'd0, 4'd3},  // R5 duplicate words, lowest wins
    {16'h1ABC, 8'hFD, 1'b1, 3'd1, 4'd3},  // R5
    {16'h5678, 8'hFB, 1'b1, 3'd2, 4'd1},  // R5
    {16'h9FFF, 8'hEF, 1'b1, 3'd4, 4'd1},  // R5
    {16'h1999, 8'hFF, 1'b0, 3'd0, 4'd3},  // R6 leading ok, trailing off
    {16'h0000, 8'hFF, 1'b0, 3'd0, 4'd0},  // R10 unwritten entries
    {16'h7234, 8'hFF, 1'b0, 3'd0, 4'd0},  // R6 trailing ok, leading off
    {16'h9FFE, 8'hFF, 1'b0, 3'd0, 4'd1}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] idx, input logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // precharge edge, then evaluation edge; returns at the following falling edge
  task automatic doSearch(input logic [15:0] key);
    @(negedge clk);
    preN = 1'b0; searchKey = key;
    @(negedge clk);
    preN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 matchN", 32'(matchN), 32'hFF);
    check("R1 hit", 32'(hit), 32'h0);
    check("R1 hitIdx", 32'(hitIdx), 32'h0);
    check("R1 count", 32'(trailEvalCount), 32'h0);

    // R2 fill entries 0..4
    doWrite(3'd0, 16'h1234);
    doWrite(3'd1, 16'h1ABC);
    doWrite(3'd2, 16'h5678);
    doWrite(3'd3, 16'h1234);
    doWrite(3'd4, 16'h9FFF);

    for (int v = 0; v < 8; v++) begin
      doSearch(VECS[v][31:16]);
      expCount = expCount + 16'(VECS[v][3:0]);
      check("R2/R5/R6 matchN", 32'(matchN), 32'(VECS[v][15:8]));
      check("R7 hit", 32'(hit), 32'(VECS[v][7]));
      check("R7 hitIdx", 32'(hitIdx), 32'(VECS[v][6:4]));
      check("R9 count", 32'(trailEvalCount), 32'(expCount));
    end

    // R4 and R11: hold with preN high while the key moves
    doSearch(16'h5678);
    expCount = expCount + 16'd1;
    searchKey = 16'h1234;
    repeat (3) @(negedge clk);
    check("R11 matchN", 32'(matchN), 32'hFB);
    check("R4 hitIdx", 32'(hitIdx), 32'd2);
    check("R11 count", 32'(trailEvalCount), 32'(expCount));

    // R3 precharge drops the result
    preN = 1'b0;
    @(negedge clk);
    check("R3 matchN", 32'(matchN), 32'hFF);
    check("R3 hit", 32'(hit), 32'h0);
    check("R9 count on precharge", 32'(trailEvalCount), 32'(expCount));

    // R8 write on the evaluation edge uses old contents
    searchKey = 16'h1234;
    @(negedge clk);
    preN = 1'b1; wrEn = 1'b1; wrIdx = 3'd0; wrData = 16'h2222;
    @(negedge clk);
    wrEn = 1'b0;
    expCount = expCount + 16'd3;
    check("R8 matchN old word", 32'(matchN), 32'hF6);
    check("R8 count", 32'(trailEvalCount), 32'(expCount));
    doSearch(16'h1234);
    expCount = expCount + 16'd2;
    check("R8 matchN new word gone", 32'(matchN), 32'hF7);
    check("R7 hitIdx after overwrite", 32'(hitIdx), 32'd3);
    doSearch(16'h2222);
    expCount = expCount + 16'd1;
    check("R8 new word", 32'(matchN), 32'hFE);
    check("R9 count final", 32'(trailEvalCount), 32'(expCount));

    // R10 invalid entries after late write to entry 7
    doWrite(3'd7, 16'h0000);
    doSearch(16'h0000);
    check("R10 only written entry", 32'(matchN), 32'h7F);
    check("R7 high index", 32'(hitIdx), 32'd7);

    // R1 reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    doSearch(16'h0000);
    check("R1 entries invalid after reset", 32'(matchN), 32'hFF);
    check("R1 count after reset", 32'(trailEvalCount), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule